// File: doc/BRIEF.md
# Power-Mode Conditional Clock Gate Controller

This block decides, for each of a parameterized set of peripheral modules, whether that module's clock should run. The decision follows the CPU power mode. Software keeps three enable masks, one each for run, sleep and deep sleep. The current mode code picks which mask is used. A per-module power-domain status input has the final say: when a module's domain is off, its clock enable is forced low whatever the masks hold.

The enable is produced as a registered, glitch-free synchronous enable for each module. A small register port lets software write the three masks and read them back. The same port reads a status word that mirrors the enable currently being applied. On the way into deep sleep the CPU reports sleep for a few cycles first, and the sleep mask applies during those cycles. A module that needs an unbroken clock must therefore have its bit set in all three masks.

Top module: `pmode_clkgate`

## Requirements
- R1: The run mask is at address 0x0, the sleep mask at 0x4 and the deep-sleep mask at 0x8. Each holds one bit per module, with bit i for module i, and all three reset to zero. Reading one of these addresses returns the stored mask. Data bits at or above the module count are ignored on write and read as zero.
- R2: The mode code selects the mask: 2'b00 selects run, 2'b01 sleep, 2'b10 deep sleep, and 2'b11 behaves as run.
- R3: When a module's power-domain input is low, its enable is low from the next clock edge, whatever its mask bits hold.
- R4: An enable reflects the mode, domain status and masks present at the previous rising edge. A change at the inputs reaches the output one cycle later and not before.
- R5: Address 0xC reads the effective enable vector that is currently driven out. Writes to 0xC change nothing.
- R6: While reset is asserted, every enable output is low.
- R7: A module with run=1, sleep=0 and deep=1 loses its clock during the sleep cycles that precede deep sleep. A module with all three bits set keeps its clock through the whole transition.
- R8: Addresses other than 0x0, 0x4, 0x8 and 0xC read as zero, and writes to them change no state.
- R9: Turning a power domain off does not alter the masks. When the domain comes back on, the module's enable returns without any rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational register read data |
| cpuMode | input | 2 | CPU power mode code |
| domainOn | input | NUM_MODS | Power-domain-on flag for each module |
| modClkEn | output | NUM_MODS | Registered clock enable for each module |

## Verification
The checker keeps its own shadow copy of the masks, built only from writes that appear on the register port. It assumes that no other agent changes them and that the address decoding is exact on all four address bits. It also assumes that the mode and domain inputs are stable around each rising edge. The bench meets these conditions by driving every input at the falling edge and by reaching the masks only through the write port. The reserved mode code and the undecoded addresses are treated as legal inputs and are exercised on purpose.

// File: rtl/pmcg_pkg.sv
package pmcg_pkg;

  // Index of each mask bank
  localparam int unsigned NUM_BANKS = 3;
  localparam int unsigned BANK_RUN   = 0;
  localparam int unsigned BANK_SLEEP = 1;
  localparam int unsigned BANK_DEEP  = 2;

  // Register byte offsets
  localparam int unsigned OFF_RUN   = 'h0;
  localparam int unsigned OFF_SLEEP = 'h4;
  localparam int unsigned OFF_DEEP  = 'h8;
  localparam int unsigned OFF_STAT  = 'hC;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_DEEP  = 2'b10,
    MODE_RSVD  = 2'b11
  } cpu_mode_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_RUN,
    RD_SLEEP,
    RD_DEEP,
    RD_STAT
  } rd_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] wrBank;   // one-hot write strobe per mask
    logic [NUM_BANKS-1:0] useBank;  // one-hot mask select by mode
    rd_sel_e              rdSel;    // read-back source
  } gate_ctrl_t;

endpackage

// File: rtl/pmcg_ctrl.sv
module pmcg_ctrl
  import pmcg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        cpuMode,
  output gate_ctrl_t        ctrl
);

  localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(OFF_RUN);
  localparam logic [ADDR_W-1:0] A_SLEEP = ADDR_W'(OFF_SLEEP);
  localparam logic [ADDR_W-1:0] A_DEEP  = ADDR_W'(OFF_DEEP);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

  // Address decode: write strobes and read source
  always_comb begin
    ctrl.wrBank = '0;
    ctrl.rdSel  = RD_NONE;
    case (regAddr)
      A_RUN: begin
        ctrl.wrBank[BANK_RUN] = regWrEn;
        ctrl.rdSel            = RD_RUN;
      end
      A_SLEEP: begin
        ctrl.wrBank[BANK_SLEEP] = regWrEn;
        ctrl.rdSel              = RD_SLEEP;
      end
      A_DEEP: begin
        ctrl.wrBank[BANK_DEEP] = regWrEn;
        ctrl.rdSel             = RD_DEEP;
      end
      A_STAT:  ctrl.rdSel = RD_STAT;
      default: ctrl.rdSel = RD_NONE;
    endcase
  end

  // Mode decode: reserved code falls back to run
  always_comb begin
    ctrl.useBank = '0;
    case (cpu_mode_e'(cpuMode))
      MODE_SLEEP: ctrl.useBank[BANK_SLEEP] = 1'b1;
      MODE_DEEP:  ctrl.useBank[BANK_DEEP]  = 1'b1;
      default:    ctrl.useBank[BANK_RUN]   = 1'b1;
    endcase
  end

endmodule

// File: rtl/pmcg_datapath.sv
module pmcg_datapath
  import pmcg_pkg::*;
#(
  parameter int unsigned NUM_MODS = 8,
  parameter int unsigned REG_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  gate_ctrl_t          ctrl,
  input  logic [NUM_MODS-1:0] wrMask,
  input  logic [NUM_MODS-1:0] domainOn,
  output logic [NUM_MODS-1:0] modClkEn,
  output logic [REG_W-1:0]    rdData
);

  logic [NUM_BANKS-1:0][NUM_MODS-1:0] bankVec;
  logic [NUM_MODS-1:0] selMask;
  logic [NUM_MODS-1:0] enNext;
  logic [NUM_MODS-1:0] enQ;

  // One mask register per power mode
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NUM_MODS-1:0] bankQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               bankQ <= '0;
      else if (ctrl.wrBank[b]) bankQ <= wrMask;
    end
    assign bankVec[b] = bankQ;
  end

  // Pick the mask for the current mode
  always_comb begin
    selMask = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (ctrl.useBank[b]) selMask = selMask | bankVec[b];
    end
  end

  // Power-domain override wins over every mask
  assign enNext = selMask & domainOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= '0;
    else       enQ <= enNext;
  end

  assign modClkEn = enQ;

  // Read-back mux
  always_comb begin
    rdData = '0;
    case (ctrl.rdSel)
      RD_RUN:   rdData[NUM_MODS-1:0] = bankVec[BANK_RUN];
      RD_SLEEP: rdData[NUM_MODS-1:0] = bankVec[BANK_SLEEP];
      RD_DEEP:  rdData[NUM_MODS-1:0] = bankVec[BANK_DEEP];
      RD_STAT:  rdData[NUM_MODS-1:0] = enQ;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/pmode_clkgate.sv
module pmode_clkgate
  import pmcg_pkg::*;
#(
  parameter int unsigned NUM_MODS = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [1:0]          cpuMode,
  input  logic [NUM_MODS-1:0] domainOn,
  output logic [NUM_MODS-1:0] modClkEn
);

  gate_ctrl_t ctrl;

  pmcg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .cpuMode (cpuMode),
    .ctrl    (ctrl)
  );

  pmcg_datapath #(.NUM_MODS(NUM_MODS), .REG_W(REG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .wrMask   (regWrData[NUM_MODS-1:0]),
    .domainOn (domainOn),
    .modClkEn (modClkEn),
    .rdData   (regRdData)
  );

endmodule

// File: rtl/pmcg_chk.sv
module pmcg_chk
  import pmcg_pkg::*;
#(
  parameter int unsigned NUM_MODS = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_W    = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [REG_W-1:0]    regWrData,
  input logic [REG_W-1:0]    regRdData,
  input logic [1:0]          cpuMode,
  input logic [NUM_MODS-1:0] domainOn,
  input logic [NUM_MODS-1:0] modClkEn
);

  logic [NUM_MODS-1:0] shRun, shSleep, shDeep, shSel, expNext;

  // Shadow masks built only from port writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shRun   <= '0;
      shSleep <= '0;
      shDeep  <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(OFF_RUN))   shRun   <= regWrData[NUM_MODS-1:0];
      if (regAddr == ADDR_W'(OFF_SLEEP)) shSleep <= regWrData[NUM_MODS-1:0];
      if (regAddr == ADDR_W'(OFF_DEEP))  shDeep  <= regWrData[NUM_MODS-1:0];
    end
  end

  always_comb begin
    case (cpuMode)
      2'b01:   shSel = shSleep;
      2'b10:   shSel = shDeep;
      default: shSel = shRun;
    endcase
  end
  assign expNext = shSel & domainOn;

  // R2 R4
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> modClkEn == $past(expNext));

  // R3
  domain_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (modClkEn & ~$past(domainOn)) == '0);

  // R5
  status_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == ADDR_W'(OFF_STAT) |-> regRdData == REG_W'(modClkEn));

  // R1
  run_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == ADDR_W'(OFF_RUN) |-> regRdData == REG_W'(shRun));

  // R6
  reset_low_chk: assert property (@(posedge clk)
    !rstN |-> modClkEn == '0);

endmodule

bind pmode_clkgate pmcg_chk #(
  .NUM_MODS (NUM_MODS),
  .ADDR_W   (ADDR_W),
  .REG_W    (REG_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .cpuMode   (cpuMode),
  .domainOn  (domainOn),
  .modClkEn  (modClkEn)
);

// File: tb/pmode_clkgate_bench.sv
module pmode_clkgate_bench;

  localparam int unsigned N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0]  cpuMode = 2'b00;
  logic [N-1:0] domainOn = '1;
  logic [N-1:0] modClkEn;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pmode_clkgate #(.NUM_MODS(N)) u_pmode_clkgate (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cpuMode(cpuMode),
    .domainOn(domainOn), .modClkEn(modClkEn)
  );

  // {mode, domainOn, expected enable} with run=AD sleep=3C deep=99
  localparam logic [17:0] VEC [0:7] = '{
    {2'b00, 8'hFF, 8'hAD},
    {2'b01, 8'hFF, 8'h3C},
    {2'b10, 8'hFF, 8'h99},
    {2'b11, 8'hFF, 8'hAD},
    {2'b00, 8'h0F, 8'h0D},
    {2'b01, 8'hF0, 8'h30},
    {2'b10, 8'h00, 8'h00},
    {2'b10, 8'hAA, 8'h88}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
  endtask

  // Apply mode/domain at a falling edge, sample after the next rising edge
  task automatic step(input logic [1:0] m, input logic [N-1:0] d);
    @(negedge clk);
    cpuMode = m; domainOn = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R6: reset holds enables low
    repeat (3) @(negedge clk);
    chk("R6 enables in reset", 32'(modClkEn), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 enables after reset", 32'(modClkEn), 32'h0);
    rdChk("R1 run reset", 4'h0, 32'h0);
    rdChk("R1 sleep reset", 4'h4, 32'h0);
    rdChk("R1 deep reset", 4'h8, 32'h0);
    rdChk("R5 status reset", 4'hC, 32'h0);

    // R1: upper bits ignored
    wr(4'h0, 32'hFFFF_FFFF);
    rdChk("R1 upper bits read zero", 4'h0, 32'h0000_00FF);

    wr(4'h0, 32'h0000_00AD);
    wr(4'h4, 32'h0000_003C);
    wr(4'h8, 32'h0000_0099);
    rdChk("R1 run readback", 4'h0, 32'hAD);
    rdChk("R1 sleep readback", 4'h4, 32'h3C);
    rdChk("R1 deep readback", 4'h8, 32'h99);

    // R2 R3: vector table
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][17:16], VEC[i][15:8]);
      chk($sformatf("R2 R3 vector %0d", i), 32'(modClkEn), 32'(VEC[i][7:0]));
      regAddr = 4'hC;
      #1;
      chk($sformatf("R5 status vector %0d", i), regRdData, 32'(VEC[i][7:0]));
    end

    // R4: one-cycle latency on a mode change
    step(2'b00, 8'hFF);
    chk("R4 settled run", 32'(modClkEn), 32'hAD);
    @(negedge clk);
    cpuMode = 2'b01;
    #1;
    chk("R4 no change before edge", 32'(modClkEn), 32'hAD);
    @(negedge clk);
    chk("R4 change after edge", 32'(modClkEn), 32'h3C);

    // R5 R8: writes to status and unused addresses ignored
    step(2'b00, 8'hFF);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'hE, 32'hFFFF_FFFF);
    chk("R5 status write ignored", 32'(modClkEn), 32'hAD);
    rdChk("R8 run untouched", 4'h0, 32'hAD);
    rdChk("R8 sleep untouched", 4'h4, 32'h3C);
    rdChk("R8 deep untouched", 4'h8, 32'h99);
    rdChk("R8 unused reads zero", 4'h2, 32'h0);
    rdChk("R8 unused high reads zero", 4'hE, 32'h0);

    // R7: deep-sleep entry passes through sleep
    wr(4'h0, 32'h3);
    wr(4'h4, 32'h2);
    wr(4'h8, 32'h3);
    step(2'b00, 8'hFF);
    chk("R7 run phase", 32'(modClkEn[1:0]), 32'h3);
    for (int c = 0; c < 3; c++) begin
      step(2'b01, 8'hFF);
      chk($sformatf("R7 sleep phase %0d", c), 32'(modClkEn[1:0]), 32'h2);
    end
    step(2'b10, 8'hFF);
    chk("R7 deep phase", 32'(modClkEn[1:0]), 32'h3);

    // R9: power cycle keeps the masks
    step(2'b00, 8'h00);
    chk("R9 domain off", 32'(modClkEn), 32'h0);
    rdChk("R9 mask kept", 4'h0, 32'h3);
    step(2'b00, 8'hFF);
    chk("R9 domain back on", 32'(modClkEn), 32'h3);

    // R6: reset mid-run clears masks
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R6 async clear", 32'(modClkEn), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    rdChk("R6 masks cleared", 4'h0, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule